// File: doc/BRIEF.md
# Hand-Driven Processor Datapath

This block is the execution core of a small 16-bit processor without its sequencer. A register bank, an arithmetic/logic unit and a word-wide RAM are joined into a single-cycle loop. Every control line (operation code, the two read selects, the write select and its enable, the store and load strobes, and the write-back source) is a top-level input. Each clock edge therefore performs exactly one register transfer that the caller has spelled out. No instruction word, decoder or program counter is present.

The first read port does double duty: it is ALU operand A and also the memory address. The second read port is ALU operand B and also the store data. A four-way write-back selector picks the value that returns to the register bank: the ALU result, the memory read word, a 16-bit value supplied from outside, or zero. The selected value is brought out for observation, along with the four ALU status flags. Its main use is to build up and check control sequences before a control unit exists to generate them.

Top module: `manual_datapath`

## Requirements
- R1: While `rst_n` is low, the four general registers (codes 1 to 4) are cleared. After reset each of them reads 0.
- R2: On a rising edge with `wr_en` high and `wr_sel` in 1..4, the selected register takes the value on `wb_data`. A register that is not selected keeps its value, and with `wr_en` low every register keeps its value.
- R3: Register code 0 always reads 0, and writes to it have no effect. Codes 5, 6 and 7 also read 0 and ignore writes.
- R4: `alu_op` picks the ALU function: 0 = A+B, 1 = A−B, 2 = A AND B, 3 = A OR B. Results wrap to 16 bits. A is the register chosen by `rd_sel_a` and B is the register chosen by `rd_sel_b`.
- R5: `flag_z` is high when the ALU result is 0, and `flag_n` equals bit 15 of the result. `flag_c` is the carry out of bit 15 on add, and on subtract it is high when A ≥ B unsigned (no borrow). `flag_v` is high on signed overflow for add and subtract. `flag_c` and `flag_v` are 0 for AND and OR.
- R6: `wb_sel` picks the write-back source: 0 = ALU result, 1 = memory read word, 2 = `user_word`, 3 = zero. The chosen value appears on `wb_data` in the same cycle.
- R7: The low 8 bits of register A address the RAM. With `mem_store` high, the word in register B is written there on the rising edge.
- R8: With `mem_load` high, the RAM read word is the addressed word in the same cycle. With `mem_load` low, it reads 0.
- R9: At power-up, RAM words 0, 1, 2 and 3 hold 0xAAAA, 0xBBBB, 0xCCCC and 0xDDDD. Every other word holds 0. Reset does not clear the RAM.
- R10: Loading words 0 and 1, adding them and storing the sum at word 2 leaves 0x6665 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register bank |
| alu_op | input | 2 | ALU function select |
| rd_sel_a | input | 3 | Register for ALU operand A and memory address |
| rd_sel_b | input | 3 | Register for ALU operand B and store data |
| wr_sel | input | 3 | Destination register code |
| wr_en | input | 1 | Register write enable |
| mem_store | input | 1 | RAM write strobe |
| mem_load | input | 1 | RAM read enable |
| wb_sel | input | 2 | Write-back source select |
| user_word | input | 16 | Externally supplied write-back value |
| wb_data | output | 16 | Selected write-back value |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 15 |
| flag_c | output | 1 | Carry / no-borrow |
| flag_v | output | 1 | Signed overflow |

## Verification
The assertions assume that `rst_n` is low from time zero for at least one edge. They also assume that control inputs change only away from the rising edge, so a write, a store and the value checked after it refer to the same settled control word. The stimulus changes every control line together at the falling edge and keeps them idle during reset. It also sets `mem_load` to match `wb_sel` only where a sequence needs memory data, so that the gated-read case with `mem_load` low is reached deliberately and not by accident.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_USER = 2'd2,
        WB_NONE = 2'd3
    } wb_sel_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;
endpackage

// File: rtl/mdp_alu.sv
module mdp_alu
    import mdp_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output flags_t       fl
);
    logic [W:0] sum_x;
    logic [W:0] dif_x;

    always_comb begin
        sum_x = {1'b0, a} + {1'b0, b};
        dif_x = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        fl    = '0;
        unique case (op)
            OP_ADD: begin
                y    = sum_x[W-1:0];
                fl.c = sum_x[W];
                fl.v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            OP_SUB: begin
                y    = dif_x[W-1:0];
                fl.c = dif_x[W];
                fl.v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            default: y = '0;
        endcase
        fl.z = (y == '0);
        fl.n = y[W-1];
    end
endmodule

// File: rtl/mdp_regbank.sv
module mdp_regbank #(
    parameter int W    = 16,
    parameter int NREG = 5,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] rd_sel_a,
    input  logic [SELW-1:0] rd_sel_b,
    input  logic [SELW-1:0] wr_sel,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    rd_a,
    output logic [W-1:0]    rd_b
);
    localparam int NCODE = 1 << SELW;

    logic [W-1:0] regs [NCODE];

    for (genvar gi = 0; gi < NCODE; gi++) begin : g_reg
        if (gi == 0 || gi >= NREG) begin : g_dead
            assign regs[gi] = '0;
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (wr_en && wr_sel == SELW'(gi))
                    regs[gi] <= wr_data;
            end

            // R2: a selected write lands on the next edge
            a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == SELW'(gi)) |=> regs[gi] == $past(wr_data));
            // R2: an unselected register holds
            a_r2_unselected_holds: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_sel == SELW'(gi)) |=> $stable(regs[gi]));
        end
    end

    assign rd_a = regs[rd_sel_a];
    assign rd_b = regs[rd_sel_b];

    // R3: the zero code reads zero however it was written
    a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_a == '0) |-> rd_a == '0);
endmodule

// File: rtl/mdp_ram.sv
module mdp_ram #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          store,
    input  logic          load,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx;

    assign idx = addr[IW-1:0];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = (i < 4) ? DW'(32'hAAAA + 32'h1111 * i) : '0;
    end

    always_ff @(posedge clk) begin
        if (store)
            mem[idx] <= wdata;
    end

    assign rdata = load ? mem[idx] : '0;

    // R7: a stored word is readable at its address on the next cycle
    a_r7_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/manual_datapath.sv
module manual_datapath
    import mdp_pkg::*;
#(
    parameter int W     = 16,
    parameter int SELW  = 3,
    parameter int NREG  = 5,
    parameter int DEPTH = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      alu_op,
    input  logic [SELW-1:0] rd_sel_a,
    input  logic [SELW-1:0] rd_sel_b,
    input  logic [SELW-1:0] wr_sel,
    input  logic            wr_en,
    input  logic            mem_store,
    input  logic            mem_load,
    input  logic [1:0]      wb_sel,
    input  logic [W-1:0]    user_word,
    output logic [W-1:0]    wb_data,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_c,
    output logic            flag_v
);
    logic [W-1:0] port_a;
    logic [W-1:0] port_b;
    logic [W-1:0] alu_y;
    logic [W-1:0] mem_q;
    flags_t       alu_fl;
    wb_sel_e      src;

    assign src = wb_sel_e'(wb_sel);

    mdp_regbank #(.W(W), .NREG(NREG), .SELW(SELW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_a (rd_sel_a),
        .rd_sel_b (rd_sel_b),
        .wr_sel   (wr_sel),
        .wr_en    (wr_en),
        .wr_data  (wb_data),
        .rd_a     (port_a),
        .rd_b     (port_b)
    );

    mdp_alu #(.W(W)) u_alu (
        .op (alu_op_e'(alu_op)),
        .a  (port_a),
        .b  (port_b),
        .y  (alu_y),
        .fl (alu_fl)
    );

    mdp_ram #(.AW(W), .DW(W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (port_a),
        .wdata (port_b),
        .store (mem_store),
        .load  (mem_load),
        .rdata (mem_q)
    );

    always_comb begin
        unique case (src)
            WB_ALU:  wb_data = alu_y;
            WB_MEM:  wb_data = mem_q;
            WB_USER: wb_data = user_word;
            default: wb_data = '0;
        endcase
    end

    assign flag_z = alu_fl.z;
    assign flag_n = alu_fl.n;
    assign flag_c = alu_fl.c;
    assign flag_v = alu_fl.v;

    // R8: memory path is silent without a load
    a_r8_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (src == WB_MEM && !mem_load) |-> wb_data == '0);
    // R5: zero flag agrees with the ALU value as seen through the selector
    a_r5_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (src == WB_ALU) |-> flag_z == (wb_data == '0));
    // R5: negative flag agrees with the selected ALU value
    a_r5_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (src == WB_ALU) |-> flag_n == wb_data[W-1]);
    // R6: the spare select code yields zero
    a_r6_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (src == WB_NONE) |-> wb_data == '0);
endmodule

// File: tb/sim_manual_datapath.sv
`timescale 1ns/1ps
module sim_manual_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alu_op = '0;
    logic [2:0]  rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
    logic        wr_en = 1'b0, mem_store = 1'b0, mem_load = 1'b0;
    logic [1:0]  wb_sel = '0;
    logic [15:0] user_word = '0;
    logic [15:0] wb_data;
    logic        flag_z, flag_n, flag_c, flag_v;

    int errors = 0;
    int checks = 0;
    int rf [8];
    int mem [256];

    always #2.5 clk = ~clk;

    manual_datapath u0 (
        .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .rd_sel_a(rd_sel_a),
        .rd_sel_b(rd_sel_b), .wr_sel(wr_sel), .wr_en(wr_en),
        .mem_store(mem_store), .mem_load(mem_load), .wb_sel(wb_sel),
        .user_word(user_word), .wb_data(wb_data), .flag_z(flag_z),
        .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic int rd(input int code);
        return (code >= 1 && code <= 4) ? rf[code] : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one control word per clock; compare on the falling side, update model at the edge
    task automatic step(input string tag, input int op, input int a, input int b,
                        input int w, input int we, input int st, input int ld,
                        input int sel, input int user);
        int av, bv, y, c, v, res, expd;
        @(negedge clk);
        alu_op = 2'(op); rd_sel_a = 3'(a); rd_sel_b = 3'(b); wr_sel = 3'(w);
        wr_en = 1'(we); mem_store = 1'(st); mem_load = 1'(ld);
        wb_sel = 2'(sel); user_word = 16'(user);
        #1;
        av = rd(a); bv = rd(b); c = 0; v = 0;
        case (op)
            0: begin
                res = av + bv; y = res & 32'hFFFF; c = (res >> 16) & 1;
                v = (((av ^ bv) & 32'h8000) == 0 && ((y ^ av) & 32'h8000) != 0) ? 1 : 0;
            end
            1: begin
                y = (av - bv) & 32'hFFFF; c = (av >= bv) ? 1 : 0;
                v = (((av ^ bv) & 32'h8000) != 0 && ((y ^ av) & 32'h8000) != 0) ? 1 : 0;
            end
            2: y = av & bv;
            default: y = av | bv;
        endcase
        case (sel)
            0: expd = y;
            1: expd = ld ? mem[av & 255] : 0;
            2: expd = user & 32'hFFFF;
            default: expd = 0;
        endcase
        check(tag, int'(wb_data), expd);
        check({tag, "/R5 flags"}, int'({flag_v, flag_c, flag_n, flag_z}),
              (v << 3) | (c << 2) | (((y >> 15) & 1) << 1) | (y == 0 ? 1 : 0));
        @(posedge clk);
        if (st) mem[av & 255] = bv;
        if (we && w >= 1 && w <= 4) rf[w] = expd;
    endtask

    task automatic put(input int w, input int val);
        step("R6 user path", 0, 0, 0, w, 1, 0, 0, 2, val);
    endtask

    task automatic peek(input string tag, input int r);
        step(tag, 3, r, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 4) ? 32'hAAAA + 32'h1111 * i : 0;
        for (int i = 0; i < 8; i++) rf[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int r = 1; r <= 4; r++) peek("R1 reset value", r);

        put(1, 1); put(2, 3); put(3, 16'hF);
        step("R2 idle edge", 0, 1, 2, 4, 0, 0, 0, 0, 0);
        for (int r = 1; r <= 4; r++) peek("R2 hold", r);

        step("R4 add", 0, 1, 3, 4, 1, 0, 0, 0, 0);
        peek("R2 written", 4);
        step("R4 sub", 1, 3, 2, 4, 1, 0, 0, 0, 0);
        step("R4 zero minus one", 1, 0, 1, 4, 1, 0, 0, 0, 0);
        peek("R2 written", 4);
        step("R4 and", 2, 3, 4, 0, 0, 0, 0, 0, 0);
        step("R4 or", 3, 1, 2, 0, 0, 0, 0, 0, 0);

        step("R3 write zero code", 0, 0, 0, 0, 1, 0, 0, 2, 16'h1234);
        peek("R3 zero code", 0);
        step("R3 write code 6", 0, 0, 0, 6, 1, 0, 0, 2, 16'h5555);
        peek("R3 code 6", 6);
        for (int r = 1; r <= 4; r++) peek("R3 others intact", r);

        put(1, 16'h7FFF);
        step("R5 add overflow", 0, 1, 2, 0, 0, 0, 0, 0, 0);
        step("R5 add carry", 0, 4, 2, 0, 0, 0, 0, 0, 0);
        step("R5 sub zero", 1, 2, 2, 0, 0, 0, 0, 0, 0);
        put(1, 16'h8000); put(2, 1);
        step("R5 sub overflow", 1, 1, 2, 0, 0, 0, 0, 0, 0);
        step("R5 sub borrow", 1, 2, 1, 0, 0, 0, 0, 0, 0);

        step("R6 spare select", 0, 1, 2, 0, 0, 0, 0, 3, 16'h9999);
        step("R8 load off", 0, 1, 2, 0, 0, 0, 0, 1, 0);
        step("R8 load off ignores user", 0, 1, 2, 0, 0, 0, 0, 1, 16'h4321);

        for (int i = 0; i < 5; i++) begin
            put(1, i);
            step("R9 initial word", 0, 1, 0, 0, 0, 0, 1, 1, 0);
        end
        put(1, 16'h01FF);
        step("R9 high word zero", 0, 1, 0, 0, 0, 0, 1, 1, 0);

        put(1, 0); put(2, 1);
        step("R8 load to reg", 0, 1, 0, 3, 1, 0, 1, 1, 0);
        step("R8 load to reg", 0, 2, 0, 4, 1, 0, 1, 1, 0);
        step("R10 sum", 0, 3, 4, 3, 1, 0, 0, 0, 0);
        put(1, 2);
        step("R7 store", 0, 1, 3, 0, 0, 1, 0, 0, 0);
        step("R10 stored sum", 0, 1, 0, 0, 0, 0, 1, 1, 0);
        check("R10 literal", int'(wb_data), 16'h6665);

        put(1, 3);
        step("R7 copy store", 0, 1, 4, 0, 0, 1, 0, 0, 0);
        step("R7 copy readback", 0, 1, 0, 0, 0, 0, 1, 1, 0);
        put(1, 0);
        step("R7 other word intact", 0, 1, 0, 0, 0, 0, 1, 1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule